// File: doc/BRIEF.md
# Compare-Match Event Timer

This peripheral is an up-counting timer behind a small word-addressed register port. Software programs a compare value, picks a prescale ratio and starts the counter. The block raises a one-cycle interrupt pulse in the first cycle the count equals the compare value. If software sets the auto-restart control bit, the count returns to zero on the tick that follows the match, so the timer gives a periodic event.

Zeroing the count is a posted operation. A write to the clear word starts a short handshake that stands in for a crossing into a slower counting domain. A pending flag in the status word stays high until the zero has landed. The usual sequence for programming the next event is: stop the timer, post a clear, load the compare value, poll the pending flag until it reads 0, then start again. The counter can be read at any time and returns its live value.

Top module: `cmt_timer`

## Requirements
- R1: While reset is held, and after it is released, the match, count, control and divider registers read 0, the status word reads 0 and `irq_o` is low.
- R2: The byte offsets of the registers are as follows. The match register is at 0x00 and can be read and written. The control register is at 0x08 and keeps bits [1:0]. The divider register is at 0x10 and keeps bits [1:0]. The clear word is at 0x0C and reads 0. The read-only status word is at 0x14. Bits of a written word that have no storage read back as 0.
- R3: Control bit 0 (run) lets the counter advance on prescaler ticks. While run is 0 the count holds its value, and the value is not reset.
- R4: Divider code d (0 to 3) makes the counter advance once every d+1 clocks. Code 3 is divide-by-4. The first advance lands d+1 clock edges after the edge that writes run=1. The prescaler restarts from zero whenever run is 0.
- R5: Any write to the clear word zeroes the counter CLR_LAT clock edges later (default 2), whatever the written data. The clear takes effect whether or not run is set.
- R6: Status bit 10 (clear pending) is 1 from the edge of the clear write until the edge on which the count becomes zero, and it falls on that same edge.
- R7: The counter is CNT_W bits wide (default 32), as is the match register. The counter goes from all ones to zero and keeps counting.
- R8: When control bit 1 (auto-restart) is set, a tick that finds the count equal to the match value loads zero instead of count+1.
- R9: `irq_o` is high for exactly one cycle: the first cycle in which the count equals the match value. It rises only while run is 1. A count that stays on the match value for several cycles gives a single pulse.
- R10: Writing to the count word at 0x04 has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the counting clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 5 | Byte address of the register word; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_o | output | 1 | One-cycle event pulse on a new match |

## Verification
Read data is combinational, so a register value written at one edge can be read in the half-cycle that follows it. The count lags each run write by exactly d+1 edges per step, and the bench samples it a whole number of edges after that write. A posted clear shows its pending flag in the half-cycle after the write edge. The flag and the count are then read after each of the next two edges, which catches a flag that falls early, late, or apart from the zeroing. The interrupt is checked in the very cycle the count first shows the match value and in the cycle after it. Pulses are also counted over whole match periods, so a pulse that lasts too long or comes again is reported.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 5;
  localparam int PEND_BIT = 10;

  typedef enum logic [2:0] {
    IDX_MATCH = 3'd0,
    IDX_COUNT = 3'd1,
    IDX_CTRL  = 3'd2,
    IDX_CLEAR = 3'd3,
    IDX_DIV   = 3'd4,
    IDX_STAT  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              pend,
  output logic [CNT_W-1:0]  match_val,
  output logic              run,
  output logic              auto_rst,
  output logic [DIV_W-1:0]  div_sel,
  output logic              clear_req,
  output logic [BUS_W-1:0]  bus_rdata
);
  reg_idx_e         idx;
  logic [CNT_W-1:0] match_q, match_d;
  logic [1:0]       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             unused_bits;

  assign idx         = reg_idx_e'(bus_addr[ADDR_W-1:2]);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_comb begin
    match_d   = match_q;
    ctrl_d    = ctrl_q;
    div_d     = div_q;
    clear_req = 1'b0;
    if (bus_wr) begin
      case (idx)
        IDX_MATCH: match_d   = bus_wdata[CNT_W-1:0];
        IDX_CTRL:  ctrl_d    = bus_wdata[1:0];
        IDX_CLEAR: clear_req = 1'b1;
        IDX_DIV:   div_d     = bus_wdata[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      ctrl_q  <= '0;
      div_q   <= '0;
    end else begin
      match_q <= match_d;
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_MATCH: bus_rdata[CNT_W-1:0] = match_q;
      IDX_COUNT: bus_rdata[CNT_W-1:0] = count;
      IDX_CTRL:  bus_rdata[1:0]       = ctrl_q;
      IDX_DIV:   bus_rdata[DIV_W-1:0] = div_q;
      IDX_STAT:  bus_rdata[PEND_BIT]  = pend;
      default:   ;
    endcase
  end

  assign match_val = match_q;
  assign run       = ctrl_q[0];
  assign auto_rst  = ctrl_q[1];
  assign div_sel   = div_q;
endmodule

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == div_sel);

  always_comb begin
    if (!run || tick) pre_d = '0;
    else              pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W   = 32,
  parameter int CLR_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             auto_rst,
  input  logic [CNT_W-1:0] match_val,
  input  logic             clear_req,
  output logic [CNT_W-1:0] count,
  output logic             pend,
  output logic             irq
);
  localparam int LAT_W = $clog2(CLR_LAT + 1);
  localparam logic [LAT_W-1:0] LAST = LAT_W'(CLR_LAT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] sync_q, sync_d;
  logic             pend_q, pend_d;
  logic             eq, eq_q;
  logic             clr_fire;

  always_comb begin
    pend_d   = pend_q;
    sync_d   = sync_q;
    clr_fire = 1'b0;
    if (clear_req) begin
      pend_d = 1'b1;
      sync_d = '0;
    end else if (pend_q) begin
      if (sync_q == LAST) begin
        pend_d   = 1'b0;
        clr_fire = 1'b1;
      end else begin
        sync_d = sync_q + 1'b1;
      end
    end
  end

  assign eq = (cnt_q == match_val);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_fire)             cnt_d = '0;
    else if (tick && auto_rst && eq) cnt_d = '0;
    else if (tick)            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= '0;
      pend_q <= 1'b0;
      eq_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
      pend_q <= pend_d;
      eq_q   <= eq;
    end
  end

  assign count = cnt_q;
  assign pend  = pend_q;
  assign irq   = run && eq && !eq_q;
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 2,
  parameter int CLR_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [1:0]       rs_q;
  logic             srst_n;
  logic [CNT_W-1:0] match_w, count_w;
  logic             run_w, auto_w, clear_w, tick_w, pend_w;
  logic [DIV_W-1:0] div_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  cmt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .count(count_w), .pend(pend_w),
    .match_val(match_w), .run(run_w), .auto_rst(auto_w), .div_sel(div_w),
    .clear_req(clear_w), .bus_rdata(bus_rdata)
  );

  cmt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(srst_n), .run(run_w), .div_sel(div_w), .tick(tick_w)
  );

  cmt_counter #(.CNT_W(CNT_W), .CLR_LAT(CLR_LAT)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run(run_w), .tick(tick_w), .auto_rst(auto_w),
    .match_val(match_w), .clear_req(clear_w), .count(count_w),
    .pend(pend_w), .irq(irq_o)
  );
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              run,
  input logic              auto_rst,
  input logic              pend,
  input logic [CNT_W-1:0]  count,
  input logic              irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr[ADDR_W-1:2] == 3'd3);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!srst_n)
    irq |=> !irq);

  p_irq_run_r9: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> run);

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!srst_n)
    clr_wr |=> pend);

  p_pend_zero_r6: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(pend) |-> (count == '0));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (!run && !pend) |=> $stable(count));

  p_step_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (run && !pend && !auto_rst) |=>
      ((count == $past(count)) || (count == $past(count) + ONE)));
endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .run(run_w), .auto_rst(auto_w), .pend(pend_w), .count(count_w), .irq(irq_o)
);

// File: tb/sim_cmt_timer.sv
module sim_cmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 12;
  localparam int LAT  = 2;
  localparam logic [4:0] A_MATCH = 5'h00, A_COUNT = 5'h04, A_CTRL = 5'h08,
                         A_CLEAR = 5'h0C, A_DIV = 5'h10, A_STAT = 5'h14;
  localparam int NVEC = 6;
  // each row: divider code, edges after run write, expected count
  localparam int VECS [NVEC][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3},
    '{3, 10, 2},  '{3, 7, 1},  '{2, 2, 0}
  };

  logic        clk, rst_n, bus_wr, irq_o;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          n_chk, n_fail;
  logic [31:0] v, c0;
  int          pulses;

  cmt_timer #(.CNT_W(CW), .CLR_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic restart(input int dcode, input logic [31:0] ctrl);
    wr(A_CTRL, 0);
    wr(A_CLEAR, 0);
    repeat (LAT) @(negedge clk);
    wr(A_DIV, dcode);
    wr(A_CTRL, ctrl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_COUNT, v); chk("R1 count", v, 0);
    rd(A_MATCH, v); chk("R1 match", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_DIV, v);   chk("R1 div", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R2 readback and field widths
    wr(A_MATCH, 32'hA5A5_A5A5); rd(A_MATCH, v); chk("R2 match", v, 32'h5A5);
    wr(A_DIV, 32'hFF);          rd(A_DIV, v);   chk("R2 div", v, 3);
    wr(A_CTRL, 32'hFFFF_FFFC);  rd(A_CTRL, v);  chk("R2 ctrl", v, 0);
    rd(A_CLEAR, v); chk("R2 clear reads 0", v, 0);

    // R4 divider table
    for (int i = 0; i < NVEC; i++) begin
      restart(VECS[i][0], 1);
      repeat (VECS[i][1]) @(negedge clk);
      rd(A_COUNT, v);
      chk($sformatf("R4 div=%0d n=%0d", VECS[i][0], VECS[i][1]), v, VECS[i][2]);
    end

    // R7 wrap
    restart(0, 1);
    repeat ((1 << CW) - 1) @(negedge clk);
    rd(A_COUNT, v); chk("R7 all ones", v, (1 << CW) - 1);
    @(negedge clk);
    rd(A_COUNT, v); chk("R7 wrapped", v, 0);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); chk("R7 after wrap", v, 5);

    // R5/R6 posted clear while running, data ignored
    wr(A_CLEAR, 32'hFFFF_FFFF);
    rd(A_STAT, v);  chk("R6 pending set", v, 32'h400);
    rd(A_COUNT, v); chk("R5 not yet zero", v, 6);
    @(negedge clk);
    rd(A_STAT, v);  chk("R6 still pending", v, 32'h400);
    rd(A_COUNT, v); chk("R5 still counting", v, 7);
    @(negedge clk);
    rd(A_STAT, v);  chk("R6 pending fell", v, 0);
    rd(A_COUNT, v); chk("R5 zeroed", v, 0);
    @(negedge clk);
    rd(A_COUNT, v); chk("R5 counts on", v, 1);

    // R8/R9 auto-restart, match 5, div 1
    wr(A_CTRL, 0);
    wr(A_CLEAR, 0);
    repeat (LAT) @(negedge clk);
    wr(A_MATCH, 5);
    wr(A_DIV, 0);
    wr(A_CTRL, 3);
    pulses = 0;
    for (int n = 1; n <= 18; n++) begin
      @(negedge clk);
      rd(A_COUNT, v);
      if (irq_o) pulses++;
      if (n == 5) begin
        chk("R8 reaches match", v, 5);
        chk("R9 pulse at match", {31'd0, irq_o}, 1);
      end
      if (n == 6) begin
        chk("R8 restarted", v, 0);
        chk("R9 pulse ends", {31'd0, irq_o}, 0);
      end
    end
    chk("R9 periodic pulses", pulses, 3);

    // R9 long equality, div 4, match 3, no auto-restart
    wr(A_CTRL, 0);
    wr(A_CLEAR, 0);
    repeat (LAT) @(negedge clk);
    wr(A_MATCH, 3);
    wr(A_DIV, 3);
    wr(A_CTRL, 1);
    pulses = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (irq_o) pulses++;
      if (n == 12) chk("R9 pulse first equal cycle", {31'd0, irq_o}, 1);
      if (n == 13) chk("R9 no repeat while equal", {31'd0, irq_o}, 0);
    end
    chk("R9 single pulse", pulses, 1);
    rd(A_COUNT, v); chk("R8 off passes match", v, 5);

    // R3 freeze, R9 gating, R10 count write
    wr(A_CTRL, 0);
    rd(A_COUNT, c0);
    repeat (10) @(negedge clk);
    rd(A_COUNT, v); chk("R3 frozen", v, c0);
    bus_addr = A_MATCH; bus_wdata = c0; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    chk("R9 no pulse while stopped", {31'd0, irq_o}, 0);
    wr(A_COUNT, 32'h123);
    rd(A_COUNT, v); chk("R10 count write ignored", v, c0);

    // R4 prescaler restart on stop
    restart(3, 1);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 0);
    wr(A_CTRL, 1);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R4 prescaler restarted", v, 0);
    @(negedge clk);
    rd(A_COUNT, v); chk("R4 first step after restart", v, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule